// File: doc/BRIEF.md
# DC-adaptive line code stream checker

This block watches a two-level serial line that has already been aligned to its unit interval (UI). It takes one line sample per clock and judges it against the rules of a DC-adaptive line code. It keeps a running digital sum value (DSV) and measures how long each high and each low pulse lasts. It also adds every two neighbouring pulses into one period and checks that sum.

A frame-start strobe splits the stream into frames. At each strobe the block reports whether the frame that just ended met two conditions: the DSV came back to zero at least once, and at least one balanced 10-UI period occurred. Every rule violation sets a sticky flag. The flags stay set until a dedicated clear input is raised. Frame length comes only from the strobe, so the block suits the nominal 2048-UI frame and any other length.

Top module: `dca_stream_monitor`

## Requirements
- R1: During and right after reset, all six error flags and `frame_stat_valid_o` are 0, and the DSV is 0.
- R2: The DSV rises by one for each sample at 1 and falls by one for each sample at 0. Once the first level change after reset has been seen, a sample that takes the DSV above +5 or below -5 sets `err_dsv_o` in the following cycle. Values of exactly +5 and -5 are legal.
- R3: A pulse that started at a level change and lasts fewer than 2 UI sets `err_short_o` in the cycle after the sample that ends it.
- R4: In a pulse that started at a level change, the seventh identical sample sets `err_long_o` in the next cycle, before the pulse ends. Six identical samples do not set it.
- R5: When two adjacent pulses both started at level changes, their summed width must lie between 4 and 10 UI. A larger or smaller sum sets `err_period_o` in the cycle after the sample that ends the second pulse.
- R6: The partial pulse in progress at reset is exempt from the width, period and DSV-range checks.
- R7: A sample taken with `frame_start_i` high is the first UI of a new frame. The first strobe after reset produces no report. Each later strobe pulses `frame_stat_valid_o` for one cycle, in the cycle after the strobe. With that pulse, `frame_zero_o` shows whether the DSV was 0 after any sample of the frame that ended, and `frame_ten_o` shows whether that frame held a 10-UI period made of two pulses of 4 to 6 UI each.
- R8: A reported frame in which the DSV never reached 0 sets `err_nozero_o`.
- R9: A reported frame with no 10-UI period (4+6, 5+5 or 6+4) sets `err_noperiod_o`.
- R10: Every error flag is sticky. A sample with `clear_i` high clears all six flags in the next cycle, and the clear wins over any violation found on that same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One rising edge per UI |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Line level for this UI |
| frame_start_i | input | 1 | High on the first UI of a frame |
| clear_i | input | 1 | Clears all sticky error flags |
| err_short_o | output | 1 | Sticky: pulse shorter than 2 UI |
| err_long_o | output | 1 | Sticky: pulse longer than 6 UI |
| err_dsv_o | output | 1 | Sticky: DSV left -5..+5 |
| err_period_o | output | 1 | Sticky: two-pulse period outside 4..10 UI |
| err_nozero_o | output | 1 | Sticky: a frame without DSV zero |
| err_noperiod_o | output | 1 | Sticky: a frame without a 10-UI period |
| frame_stat_valid_o | output | 1 | One-cycle pulse with the frame report |
| frame_zero_o | output | 1 | Report: DSV reached zero in the frame |
| frame_ten_o | output | 1 | Report: a 10-UI period occurred in the frame |

## Verification
The hardest case to reach is a violation that must show up on its own: a period of 12 UI, or a DSV of +6, while every pulse stays 2 to 6 UI wide. The bench builds these from short hand-crafted run sequences and works out the DSV offset first. For example, 4 high and 6 low UI leave the sum at -2, so a later 7-UI or 6+6 run stays inside the DSV band. The bench then samples at the exact UI where only the intended flag may rise. Frames that miss the DSV zero are built the same way: an offset first, then 3-UI pulses that swing between +2 and +5.

// File: rtl/dca_mon_pkg.sv
`timescale 1ns/1ps
package dca_mon_pkg;

  typedef struct packed {
    logic short_w;
    logic long_w;
    logic dsv;
    logic period;
    logic nozero;
    logic noperiod;
  } dca_err_t;

  // One UI of running-sum arithmetic.
  function automatic int dsv_step(input int sum, input logic lvl);
    return lvl ? sum + 1 : sum - 1;
  endfunction

  // True when a sum lies outside the symmetric band +/-lim.
  function automatic logic dsv_outside(input int sum, input int lim);
    return (sum > lim) || (sum < -lim);
  endfunction

  // Saturate a sum to +/-sat so that a broken stream cannot wrap.
  function automatic int dsv_clamp(input int sum, input int sat);
    if (sum > sat) return sat;
    if (sum < -sat) return -sat;
    return sum;
  endfunction

endpackage

// File: rtl/dca_dsv_tracker.sv
`timescale 1ns/1ps
module dca_dsv_tracker
  import dca_mon_pkg::*;
#(
  parameter int DSV_LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic arm_i,
  output logic zero_o,
  output logic bad_o
);
  localparam int DSV_W = $clog2(DSV_LIM + 1) + 3;
  localparam int SAT   = (2 ** (DSV_W - 1)) - 1;

  logic signed [DSV_W-1:0] dsv_q, dsv_d;
  int sum_nxt;

  always_comb begin
    sum_nxt = dsv_clamp(dsv_step(int'(dsv_q), bit_i), SAT);
    dsv_d   = DSV_W'(sum_nxt);
  end

  assign zero_o = (sum_nxt == 0);
  assign bad_o  = arm_i && dsv_outside(sum_nxt, DSV_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dsv_q <= '0;
    else        dsv_q <= dsv_d;
  end
endmodule

// File: rtl/dca_run_tracker.sv
`timescale 1ns/1ps
module dca_run_tracker #(
  parameter int MIN_W   = 2,
  parameter int MAX_W   = 6,
  parameter int PER_MIN = 4,
  parameter int PER_MAX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic edge_o,
  output logic short_o,
  output logic long_o,
  output logic period_bad_o,
  output logic ten_o,
  output logic armed_o
);
  localparam int RW = $clog2(MAX_W + 2);
  localparam int PW = $clog2(2 * MAX_W + 3);
  localparam logic [RW-1:0] MIN_C = RW'(MIN_W);
  localparam logic [RW-1:0] MAX_C = RW'(MAX_W);
  localparam logic [RW-1:0] SAT_C = RW'(MAX_W + 1);
  localparam logic [RW-1:0] TEN_C = RW'(PER_MAX - MAX_W);
  localparam logic [PW-1:0] PMIN_C = PW'(PER_MIN);
  localparam logic [PW-1:0] PMAX_C = PW'(PER_MAX);

  logic          prev_q, have_q, full_q, pfull_q;
  logic [RW-1:0] run_q, last_q;
  logic [PW-1:0] per;
  logic          done, pair;

  assign edge_o  = have_q && (bit_i != prev_q);
  assign done    = edge_o && full_q;
  assign pair    = done && pfull_q;
  assign per     = PW'(last_q) + PW'(run_q);
  assign armed_o = full_q;

  assign short_o      = done && (run_q < MIN_C);
  assign long_o       = full_q && have_q && !edge_o && (run_q == MAX_C);
  assign period_bad_o = pair && ((per < PMIN_C) || (per > PMAX_C));
  assign ten_o        = pair && (per == PMAX_C) && (last_q >= TEN_C) && (run_q >= TEN_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      have_q  <= 1'b0;
      full_q  <= 1'b0;
      pfull_q <= 1'b0;
      run_q   <= '0;
      last_q  <= '0;
    end else begin
      prev_q <= bit_i;
      have_q <= 1'b1;
      if (!have_q) begin
        run_q <= RW'(1);
      end else if (edge_o) begin
        run_q   <= RW'(1);
        full_q  <= 1'b1;
        pfull_q <= full_q;
        last_q  <= run_q;
      end else if (run_q != SAT_C) begin
        run_q <= run_q + RW'(1);
      end
    end
  end
endmodule

// File: rtl/dca_frame_judge.sv
`timescale 1ns/1ps
module dca_frame_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic zero_ev_i,
  input  logic ten_ev_i,
  output logic miss_zero_o,
  output logic miss_ten_o,
  output logic stat_valid_o,
  output logic stat_zero_o,
  output logic stat_ten_o
);
  logic armed_q, zero_seen_q, ten_seen_q;
  logic judge;

  assign judge       = strobe_i && armed_q;
  assign miss_zero_o = judge && !zero_seen_q;
  assign miss_ten_o  = judge && !ten_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      zero_seen_q  <= 1'b0;
      ten_seen_q   <= 1'b0;
      stat_valid_o <= 1'b0;
      stat_zero_o  <= 1'b0;
      stat_ten_o   <= 1'b0;
    end else begin
      stat_valid_o <= judge;
      if (judge) begin
        stat_zero_o <= zero_seen_q;
        stat_ten_o  <= ten_seen_q;
      end
      if (strobe_i) begin
        armed_q     <= 1'b1;
        zero_seen_q <= zero_ev_i;
        ten_seen_q  <= ten_ev_i;
      end else begin
        zero_seen_q <= zero_seen_q | zero_ev_i;
        ten_seen_q  <= ten_seen_q | ten_ev_i;
      end
    end
  end
endmodule

// File: rtl/dca_stream_monitor.sv
`timescale 1ns/1ps
module dca_stream_monitor
  import dca_mon_pkg::*;
#(
  parameter int DSV_LIM = 5,
  parameter int MIN_W   = 2,
  parameter int MAX_W   = 6,
  parameter int PER_MIN = 4,
  parameter int PER_MAX = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic frame_start_i,
  input  logic clear_i,
  output logic err_short_o,
  output logic err_long_o,
  output logic err_dsv_o,
  output logic err_period_o,
  output logic err_nozero_o,
  output logic err_noperiod_o,
  output logic frame_stat_valid_o,
  output logic frame_zero_o,
  output logic frame_ten_o
);
  logic edge_w, short_w, long_w, period_w, ten_w, armed_w;
  logic zero_w, dsv_bad_w, miss_zero_w, miss_ten_w;
  dca_err_t ev_w, err_q;

  dca_run_tracker #(
    .MIN_W(MIN_W), .MAX_W(MAX_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX)
  ) i_run (
    .clk(clk), .rst_n(rst_n), .bit_i(line_i),
    .edge_o(edge_w), .short_o(short_w), .long_o(long_w),
    .period_bad_o(period_w), .ten_o(ten_w), .armed_o(armed_w)
  );

  dca_dsv_tracker #(.DSV_LIM(DSV_LIM)) i_dsv (
    .clk(clk), .rst_n(rst_n), .bit_i(line_i), .arm_i(armed_w),
    .zero_o(zero_w), .bad_o(dsv_bad_w)
  );

  dca_frame_judge i_frame (
    .clk(clk), .rst_n(rst_n), .strobe_i(frame_start_i),
    .zero_ev_i(zero_w), .ten_ev_i(ten_w),
    .miss_zero_o(miss_zero_w), .miss_ten_o(miss_ten_w),
    .stat_valid_o(frame_stat_valid_o), .stat_zero_o(frame_zero_o),
    .stat_ten_o(frame_ten_o)
  );

  always_comb begin
    ev_w.short_w  = short_w;
    ev_w.long_w   = long_w;
    ev_w.dsv      = dsv_bad_w;
    ev_w.period   = period_w;
    ev_w.nozero   = miss_zero_w;
    ev_w.noperiod = miss_ten_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= '0;
    else if (clear_i) err_q <= '0;
    else              err_q <= err_q | ev_w;
  end

  assign err_short_o    = err_q.short_w;
  assign err_long_o     = err_q.long_w;
  assign err_dsv_o      = err_q.dsv;
  assign err_period_o   = err_q.period;
  assign err_nozero_o   = err_q.nozero;
  assign err_noperiod_o = err_q.noperiod;
endmodule

// File: rtl/dca_stream_monitor_chk.sv
`timescale 1ns/1ps
module dca_stream_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic line_i,
  input logic frame_start_i,
  input logic clear_i,
  input logic edge_w,
  input logic dsv_bad_w,
  input logic err_short_o,
  input logic err_long_o,
  input logic err_dsv_o,
  input logic err_period_o,
  input logic err_nozero_o,
  input logic err_noperiod_o,
  input logic frame_stat_valid_o
);
  // R4
  long_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_long_o) |-> ($past(line_i) == $past(line_i, 2)));

  // R3
  short_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_short_o) |-> $past(edge_w));

  // R2
  dsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsv_bad_w && !clear_i) |=> err_dsv_o);

  // R10
  short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_short_o && !clear_i) |=> err_short_o);

  // R10
  clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !(err_short_o || err_long_o || err_dsv_o || err_period_o
                  || err_nozero_o || err_noperiod_o));

  // R7
  report_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stat_valid_o |-> $past(frame_start_i));
endmodule

bind dca_stream_monitor dca_stream_monitor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .line_i(line_i), .frame_start_i(frame_start_i),
  .clear_i(clear_i), .edge_w(edge_w), .dsv_bad_w(dsv_bad_w),
  .err_short_o(err_short_o), .err_long_o(err_long_o), .err_dsv_o(err_dsv_o),
  .err_period_o(err_period_o), .err_nozero_o(err_nozero_o),
  .err_noperiod_o(err_noperiod_o), .frame_stat_valid_o(frame_stat_valid_o)
);

// File: tb/test_dca_stream_monitor.sv
`timescale 1ns/1ps
module test_dca_stream_monitor;
  logic clk = 1'b0;
  logic rst_n, line, fs, clr;
  logic e_short, e_long, e_dsv, e_per, e_nz, e_np, st_v, st_z, st_t;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dca_stream_monitor i_dca_stream_monitor (
    .clk(clk), .rst_n(rst_n), .line_i(line), .frame_start_i(fs), .clear_i(clr),
    .err_short_o(e_short), .err_long_o(e_long), .err_dsv_o(e_dsv),
    .err_period_o(e_per), .err_nozero_o(e_nz), .err_noperiod_o(e_np),
    .frame_stat_valid_o(st_v), .frame_zero_o(st_z), .frame_ten_o(st_t)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // flag order: short long dsv period nozero noperiod
  task automatic chk_flags(input string tag, input logic [5:0] exp);
    chk(tag, int'({e_short, e_long, e_dsv, e_per, e_nz, e_np}), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line = 1'b0; fs = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One UI, driven at a falling edge; outputs are settled on return.
  task automatic ui(input logic b, input logic f = 1'b0, input logic c = 1'b0);
    line = b; fs = f; clr = c;
    @(negedge clk);
    fs = 1'b0; clr = 1'b0;
  endtask

  task automatic run(input logic b, input int n);
    for (int i = 0; i < n; i++) ui(b);
  endtask

  task automatic t_reset();
    do_reset();
    chk_flags("R1 flags after reset", 6'b0);
    chk("R1 report idle after reset", int'(st_v), 0);
    // a run of zeros from a cleared DSV reaches -6 only when armed; check band via flags
    ui(1'b1, 1'b1);
    chk("R7 first strobe gives no report", int'(st_v), 0);
    chk_flags("R7 first strobe sets no frame flag", 6'b0);
  endtask

  task automatic t_legal55();
    do_reset();
    ui(1'b1, 1'b1); run(1'b1, 4);
    for (int k = 0; k < 3; k++) begin run(1'b0, 5); run(1'b1, 5); end
    run(1'b0, 5);
    ui(1'b1, 1'b1);
    chk("R7 report valid 5+5", int'(st_v), 1);
    chk("R7 zero seen 5+5", int'(st_z), 1);
    chk("R7 ten seen 5+5", int'(st_t), 1);
    chk_flags("R2 R5 R8 R9 legal 5+5 stream clean", 6'b0);
    ui(1'b1);
    chk("R7 report lasts one cycle", int'(st_v), 0);
  endtask

  task automatic t_legal46();
    do_reset();
    ui(1'b1, 1'b1); run(1'b1, 3);
    run(1'b0, 6); run(1'b1, 4); run(1'b0, 4); run(1'b1, 6); run(1'b0, 4);
    ui(1'b1, 1'b1);
    chk("R7 report valid 4/6 mix", int'(st_v), 1);
    chk("R9 ten seen 4/6 mix", int'(st_t), 1);
    chk_flags("R5 legal 4/6 mix clean", 6'b0);
  endtask

  task automatic t_short();
    do_reset();
    run(1'b1, 5); run(1'b0, 5); ui(1'b1);
    chk_flags("R3 no flag before short pulse ends", 6'b0);
    ui(1'b0);
    chk_flags("R3 one-UI pulse flagged", 6'b100000);
  endtask

  task automatic t_long();
    do_reset();
    run(1'b1, 4); run(1'b0, 6); run(1'b1, 6);
    chk_flags("R4 six identical UI legal", 6'b0);
    ui(1'b1);
    chk_flags("R4 seventh identical UI flagged at once", 6'b010000);
  endtask

  task automatic t_dsv();
    do_reset();
    run(1'b1, 5); run(1'b0, 5); run(1'b1, 5);
    chk_flags("R2 DSV at +5 legal", 6'b0);
    ui(1'b1);
    chk_flags("R2 DSV at +6 flagged", 6'b001000);
  endtask

  task automatic t_period();
    do_reset();
    run(1'b1, 4); run(1'b0, 6); run(1'b1, 6);
    chk_flags("R5 no flag before 6+6 closes", 6'b0);
    ui(1'b0);
    chk_flags("R5 12-UI period flagged", 6'b000100);
  endtask

  task automatic t_partial();
    do_reset();
    ui(1'b1); run(1'b0, 5); run(1'b1, 5);
    chk_flags("R6 partial one-UI pulse exempt", 6'b0);
    do_reset();
    run(1'b1, 8);
    chk_flags("R6 partial eight-UI pulse exempt from width and DSV", 6'b0);
  endtask

  task automatic t_nozero();
    do_reset();
    run(1'b1, 5); run(1'b0, 3);
    ui(1'b1, 1'b1); run(1'b1, 2);
    for (int k = 0; k < 3; k++) begin run(1'b0, 3); run(1'b1, 3); end
    run(1'b0, 3);
    ui(1'b1, 1'b1);
    chk("R7 report valid offset frame", int'(st_v), 1);
    chk("R8 zero not seen", int'(st_z), 0);
    chk("R9 ten not seen", int'(st_t), 0);
    chk_flags("R8 R9 both frame flags set", 6'b000011);
  endtask

  task automatic t_noten_clear();
    do_reset();
    ui(1'b1, 1'b1); run(1'b1, 2);
    for (int k = 0; k < 2; k++) begin run(1'b0, 3); run(1'b1, 3); end
    run(1'b0, 3);
    ui(1'b1, 1'b1);
    chk("R7 zero seen in 3+3 frame", int'(st_z), 1);
    chk_flags("R9 missing ten flagged alone", 6'b000001);
    run(1'b1, 2); run(1'b0, 3);
    chk_flags("R10 flag stays set", 6'b000001);
    ui(1'b1, 1'b0, 1'b1);
    chk_flags("R10 clear wipes flags", 6'b0);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_legal55();
    t_legal46();
    t_short();
    t_long();
    t_dsv();
    t_period();
    t_partial();
    t_nozero();
    t_noten_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule